// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block sits between a simple register port and an external successive-approximation converter core. Software writes a control word that picks one of eight analog inputs, an averaging setting and a reference source, and sets a start bit. The block then runs a burst of conversions on the selected input and sums the samples. It stores the mean as a 10-bit value and raises an interrupt line. A read of the averaged-result word drops the interrupt.

The block also produces the converter clock. Its low and high phases are each programmed as a count of bus-clock cycles. When a burst ends, the averaged value is also copied into the data word of the channel that was converted. The block also holds eight general channel control words and a scan-rate word, which it stores for software but does not interpret.

Samples arrive over a valid/ready handshake. `smp_ready` is high only while the sequencer is waiting for the result of a conversion it has started. A sample is taken only on a clock edge where `smp_valid` and `smp_ready` are both high. The converter may hold `smp_valid` high for as long as it likes before `smp_ready` rises. It must keep `smp_data` stable until the sample is taken.

Top module: `adc_avg_seq`

Word addresses: 0 control/status, 1 clock phases, 2 scan rate, 3 averaged result, 8 to 15 channel control (channel = address − 8), 16 to 23 channel data (channel = address − 16). Any other address reads zero.

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `adc_clk` is low.
- R2: Control word layout: bit 0 is the start strobe, bits 3:1 are the channel, bit 4 enables the converter, bits 8:5 are the averaging setting N, and bit 9 selects the internal reference. Bit 10 is a read-only busy flag. Bit 0 always reads 0. A write with bit 0 set and bit 4 clear stores the other fields but starts nothing.
- R3: With N = 0, the block runs exactly one conversion, and the stored result equals that sample.
- R4: With N > 0, the block runs 2^N conversions and stores the sum shifted right by N, truncated. The sum never overflows, even when every sample is 1023.
- R5: `irq` rises in the cycle after the sequence ends and stays high until a read of address 3. A read of address 3 clears it at the next edge. `irq` falls for no other reason.
- R6: At the end of a sequence, the averaged value is also written into the channel data word of the converted channel.
- R7: While bit 4 is set, `adc_clk` stays low for `max(L,1)` cycles and high for `max(H,1)` cycles. L is bits 3:0 and H is bits 7:4 of address 1. While bit 4 is clear, `adc_clk` is low.
- R8: While busy, writes to the control word are ignored, including the start strobe. After the sequence, the word still holds the fields of the accepted start.
- R9: Each conversion begins with a one-cycle `conv_start` pulse in the cycle after acceptance, or in the cycle after the previous sample was taken. `smp_ready` is high only after that pulse, while a sample is awaited. `conv_chan` and `conv_vref_int` hold still for the whole sequence.
- R10: The scan-rate word and the channel control words store and return 16 bits. The result and data words return the value in bits 9:0. All bits above those read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 3) |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| adc_clk | output | 1 | Converter clock |
| conv_en | output | 1 | Converter enable |
| conv_chan | output | 3 | Selected analog input |
| conv_vref_int | output | 1 | Internal reference select |
| conv_start | output | 1 | One-cycle conversion start pulse |
| smp_valid | input | 1 | Converter sample valid |
| smp_data | input | 10 | Converter sample |
| smp_ready | output | 1 | Sequencer ready for a sample |
| irq | output | 1 | Sequence-complete interrupt |

## Verification
The sequencer is tried with five sample patterns:
- A single conversion shows that N = 0 bypasses averaging.
- A four-sample burst whose sum is not a multiple of four shows truncation as opposed to rounding.
- An eight-sample burst at full scale shows that the sum has room to grow.
- Samples offered early, while `smp_ready` is still low, are told apart from samples offered late, after a delay. This shows that only handshaken samples are counted.
- A control write made in the middle of a sequence shows that the channel and fields stay frozen.

The clock generator is driven with unequal phases and with zero phases. This separates the phase counting from the clamp to one cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int A_CTRL = 0;
  localparam int A_CLK  = 1;
  localparam int A_SCAN = 2;
  localparam int A_RES  = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PH_W-1:0] lo_cnt,
  input  logic [PH_W-1:0] hi_cnt,
  output logic            adc_clk
);
  logic [PH_W-1:0] cnt_q;
  logic            clk_q;
  logic [PH_W-1:0] lo_len, hi_len, cur_len;

  // a zero phase count is clamped to one cycle
  always_comb begin
    lo_len  = (lo_cnt == '0) ? PH_W'(1) : lo_cnt;
    hi_len  = (hi_cnt == '0) ? PH_W'(1) : hi_cnt;
    cur_len = clk_q ? hi_len : lo_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      clk_q <= 1'b0;
      cnt_q <= '0;
    end else if (({1'b0, cnt_q} + 1'b1) >= {1'b0, cur_len}) begin
      clk_q <= ~clk_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign adc_clk = clk_q;
endmodule

// File: rtl/adc_avg_core.sv
module adc_avg_core
  import adc_seq_pkg::*;
#(
  parameter int SMP_W = 10,
  parameter int AVG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AVG_W-1:0] avg_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             smp_ready,
  output logic             conv_start,
  output logic             busy,
  output logic             done,
  output logic [SMP_W-1:0] result
);
  localparam int AVG_MAX = (1 << AVG_W) - 1;
  localparam int ACC_W   = SMP_W + AVG_MAX;
  localparam int CNT_W   = AVG_MAX + 2;

  seq_state_e       st_q;
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, target;
  logic [SMP_W-1:0] res_q;
  logic             take;

  always_comb begin
    take    = (st_q == SQ_WAIT) && smp_valid;
    acc_nxt = acc_q + ACC_W'(smp_data);
    cnt_nxt = cnt_q + 1'b1;
    target  = CNT_W'(1) << avg_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      acc_q <= '0;
      cnt_q <= '0;
      res_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (start) begin
            st_q  <= SQ_ISSUE;
            acc_q <= '0;
            cnt_q <= '0;
          end
        end
        SQ_ISSUE: st_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (take) begin
            acc_q <= acc_nxt;
            cnt_q <= cnt_nxt;
            if (cnt_nxt == target) begin
              st_q  <= SQ_DONE;
              res_q <= SMP_W'(acc_nxt >> avg_n);
            end else begin
              st_q <= SQ_ISSUE;
            end
          end
        end
        SQ_DONE: st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign conv_start = (st_q == SQ_ISSUE);
  assign smp_ready  = (st_q == SQ_WAIT);
  assign busy       = (st_q != SQ_IDLE);
  assign done       = (st_q == SQ_DONE);
  assign result     = res_q;
endmodule

// File: rtl/adc_reg_bank.sv
module adc_reg_bank
  import adc_seq_pkg::*;
#(
  parameter int CH_N   = 8,
  parameter int SMP_W  = 10,
  parameter int AVG_W  = 4,
  parameter int PH_W   = 4,
  parameter int SCAN_W = 16,
  parameter int CTL_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic [SMP_W-1:0]  seq_result,
  output logic              start_req,
  output logic              en,
  output logic [CH_W-1:0]   chan,
  output logic [AVG_W-1:0]  avg_n,
  output logic              vref_int,
  output logic [PH_W-1:0]   lo_cnt,
  output logic [PH_W-1:0]   hi_cnt,
  output logic              irq
);
  localparam int CB_CH   = 1;
  localparam int CB_EN   = CB_CH + CH_W;
  localparam int CB_AVG  = CB_EN + 1;
  localparam int CB_VREF = CB_AVG + AVG_W;
  localparam int CB_BUSY = CB_VREF + 1;
  localparam int A_CHC   = CH_N;
  localparam int A_CHD   = 2 * CH_N;

  logic                  en_q, vref_q, irq_q;
  logic [CH_W-1:0]       ch_q;
  logic [AVG_W-1:0]      avg_q;
  logic [PH_W-1:0]       lo_q, hi_q;
  logic [SCAN_W-1:0]     scan_q;
  logic [SMP_W-1:0]      res_q;
  logic [CH_N*CTL_W-1:0] chctl_flat;
  logic [CH_N*SMP_W-1:0] chdat_flat;
  logic                  ctrl_wr;
  logic [ADDR_W-1:0]     idx_c, idx_d;

  assign ctrl_wr   = wr && (addr == ADDR_W'(A_CTRL)) && !seq_busy;
  assign start_req = ctrl_wr && wdata[0] && wdata[CB_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ch_q   <= '0;
      avg_q  <= '0;
      vref_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      scan_q <= '0;
      res_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wdata[CB_EN];
        ch_q   <= wdata[CB_CH +: CH_W];
        avg_q  <= wdata[CB_AVG +: AVG_W];
        vref_q <= wdata[CB_VREF];
      end
      if (wr && addr == ADDR_W'(A_CLK)) begin
        lo_q <= wdata[PH_W-1:0];
        hi_q <= wdata[2*PH_W-1:PH_W];
      end
      if (wr && addr == ADDR_W'(A_SCAN)) scan_q <= wdata[SCAN_W-1:0];
      if (seq_done) res_q <= seq_result;
      // completion wins over a simultaneous clearing read
      if (seq_done) irq_q <= 1'b1;
      else if (rd && addr == ADDR_W'(A_RES)) irq_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic [CTL_W-1:0] ctl_q;
    logic [SMP_W-1:0] dat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= '0;
        dat_q <= '0;
      end else begin
        if (wr && addr == ADDR_W'(A_CHC + g)) ctl_q <= wdata[CTL_W-1:0];
        if (seq_done && ch_q == CH_W'(g)) dat_q <= seq_result;
      end
    end
    assign chctl_flat[g*CTL_W +: CTL_W] = ctl_q;
    assign chdat_flat[g*SMP_W +: SMP_W] = dat_q;
  end

  always_comb begin
    idx_c = addr - ADDR_W'(A_CHC);
    idx_d = addr - ADDR_W'(A_CHD);
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL)) begin
      rdata[CB_CH +: CH_W]   = ch_q;
      rdata[CB_EN]           = en_q;
      rdata[CB_AVG +: AVG_W] = avg_q;
      rdata[CB_VREF]         = vref_q;
      rdata[CB_BUSY]         = seq_busy;
    end else if (addr == ADDR_W'(A_CLK)) begin
      rdata[2*PH_W-1:0] = {hi_q, lo_q};
    end else if (addr == ADDR_W'(A_SCAN)) begin
      rdata[SCAN_W-1:0] = scan_q;
    end else if (addr == ADDR_W'(A_RES)) begin
      rdata[SMP_W-1:0] = res_q;
    end else if (addr >= ADDR_W'(A_CHC) && addr < ADDR_W'(A_CHC + CH_N)) begin
      rdata[CTL_W-1:0] = chctl_flat[CH_W'(idx_c)*CTL_W +: CTL_W];
    end else if (addr >= ADDR_W'(A_CHD) && addr < ADDR_W'(A_CHD + CH_N)) begin
      rdata[SMP_W-1:0] = chdat_flat[CH_W'(idx_d)*SMP_W +: SMP_W];
    end
  end

  assign en       = en_q;
  assign chan     = ch_q;
  assign avg_n    = avg_q;
  assign vref_int = vref_q;
  assign lo_cnt   = lo_q;
  assign hi_cnt   = hi_q;
  assign irq      = irq_q;
endmodule

// File: rtl/adc_avg_seq.sv
module adc_avg_seq #(
  parameter int  CH_N   = 8,
  parameter int  SMP_W  = 10,
  parameter int  AVG_W  = 4,
  parameter int  PH_W   = 4,
  parameter int  SCAN_W = 16,
  parameter int  CTL_W  = 16,
  parameter int  DATA_W = 32,
  localparam int CH_W   = $clog2(CH_N),
  localparam int ADDR_W = $clog2(3 * CH_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              adc_clk,
  output logic              conv_en,
  output logic [CH_W-1:0]   conv_chan,
  output logic              conv_vref_int,
  output logic              conv_start,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              smp_ready,
  output logic              irq
);
  logic             start_req, seq_busy, seq_done;
  logic [SMP_W-1:0] seq_result;
  logic [AVG_W-1:0] avg_n;
  logic [PH_W-1:0]  lo_cnt, hi_cnt;

  adc_reg_bank #(
    .CH_N(CH_N), .SMP_W(SMP_W), .AVG_W(AVG_W), .PH_W(PH_W),
    .SCAN_W(SCAN_W), .CTL_W(CTL_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .seq_busy(seq_busy),
    .seq_done(seq_done), .seq_result(seq_result), .start_req(start_req),
    .en(conv_en), .chan(conv_chan), .avg_n(avg_n), .vref_int(conv_vref_int),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .irq(irq)
  );

  adc_avg_core #(.SMP_W(SMP_W), .AVG_W(AVG_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_req), .avg_n(avg_n),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .conv_start(conv_start), .busy(seq_busy), .done(seq_done),
    .result(seq_result)
  );

  adc_clk_gen #(.PH_W(PH_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(conv_en), .lo_cnt(lo_cnt),
    .hi_cnt(hi_cnt), .adc_clk(adc_clk)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              conv_start,
  input logic              smp_ready,
  input logic              busy,
  input logic              irq,
  input logic              adc_clk,
  input logic              conv_en,
  input logic [CH_W-1:0]   conv_chan
);
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R9
  start_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && smp_ready));

  // R9
  first_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> conv_start);

  // R9
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(conv_chan));

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy));

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_rd && reg_addr == ADDR_W'(A_RES)));

  // R7
  clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_en) |-> !adc_clk);
endmodule

bind adc_avg_seq adc_seq_chk #(.CH_W(CH_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .conv_start(conv_start), .smp_ready(smp_ready), .busy(seq_busy),
  .irq(irq), .adc_clk(adc_clk), .conv_en(conv_en), .conv_chan(conv_chan)
);

// File: tb/test_adc_avg_seq.sv
`timescale 1ns/1ps
module test_adc_avg_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        adc_clk, conv_en, conv_vref_int, conv_start, smp_ready, irq;
  logic [2:0]  conv_chan;
  logic        smp_valid = 1'b0;
  logic [9:0]  smp_data = '0;

  int n_chk = 0, n_bad = 0, wd = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  adc_avg_seq i_adc_avg_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adc_clk(adc_clk), .conv_en(conv_en), .conv_chan(conv_chan),
    .conv_vref_int(conv_vref_int), .conv_start(conv_start),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 issue, 2 wait, 3 done
  int m_st, m_cnt, m_pc, m_ch, m_avg, m_lo, m_hi;
  bit m_irq, m_clk, m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pc = 0; m_ch = 0; m_avg = 0; m_lo = 0; m_hi = 0;
      m_irq = 0; m_clk = 0; m_en = 0;
    end else begin
      int len;
      bit was_busy, fin;
      was_busy = (m_st != 0);
      fin = 0;
      if (!m_en) begin
        m_clk = 0; m_pc = 0;
      end else begin
        len = m_clk ? (m_hi == 0 ? 1 : m_hi) : (m_lo == 0 ? 1 : m_lo);
        if (m_pc + 1 >= len) begin m_clk = !m_clk; m_pc = 0; end
        else m_pc++;
      end
      case (m_st)
        0: if (reg_wr && reg_addr == 0 && reg_wdata[0] && reg_wdata[4]) begin
             m_st = 1; m_cnt = 0;
           end
        1: m_st = 2;
        2: if (smp_valid) begin
             m_cnt++;
             m_st = (m_cnt == (1 << m_avg)) ? 3 : 1;
           end
        default: begin m_st = 0; m_irq = 1; fin = 1; end
      endcase
      if (reg_rd && reg_addr == 3 && !fin) m_irq = 0;
      if (reg_wr && reg_addr == 0 && !was_busy) begin
        m_en = reg_wdata[4]; m_ch = int'(reg_wdata[3:1]); m_avg = int'(reg_wdata[8:5]);
      end
      if (reg_wr && reg_addr == 1) begin
        m_lo = int'(reg_wdata[3:0]); m_hi = int'(reg_wdata[7:4]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R7 adc_clk per cycle", 32'(adc_clk), 32'(m_clk));
      chk("R9 conv_start per cycle", 32'(conv_start), 32'(m_st == 1));
      chk("R9 smp_ready per cycle", 32'(smp_ready), 32'(m_st == 2));
      chk("R5 irq per cycle", 32'(irq), 32'(m_irq));
      if (m_st != 0) chk("R9 conv_chan held", 32'(conv_chan), 32'(m_ch));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 5'(a);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run_seq(input int ch, input int n, input bit vref, input int dly,
                         input bit poke, input int smp[$]);
    logic [31:0] ctl, d;
    int sum = 0, waitc;
    bit rdy;
    ctl = 32'(1 | (ch << 1) | (1 << 4) | (n << 5) | (int'(vref) << 9));
    wr_reg(0, ctl);
    for (int i = 0; i < (1 << n); i++) begin
      while (!conv_start) @(negedge clk);
      if (i == 0) begin
        chk("R2 channel field drives conv_chan", 32'(conv_chan), 32'(ch));
        chk("R2 reference field drives conv_vref_int", 32'(conv_vref_int), 32'(vref));
        if (poke) wr_reg(0, 32'(1 | ((ch ^ 7) << 1) | (1 << 4)));
      end
      repeat (dly) @(negedge clk);
      smp_valid = 1'b1; smp_data = 10'(smp[i]);
      sum += smp[i];
      forever begin
        rdy = smp_ready;
        @(negedge clk);
        if (rdy) break;
      end
      smp_valid = 1'b0;
    end
    waitc = 0;
    while (!irq && waitc < 10) begin @(negedge clk); waitc++; end
    chk("R5 irq raised at end of sequence", 32'(irq), 32'd1);
    rd_reg(0, d);
    chk("R8 control fields kept, busy clear, start reads 0", d, ctl & ~32'h1);
    rd_reg(16 + ch, d);
    chk("R6 channel data holds mean", d, 32'(sum >> n));
    chk("R5 irq held through other reads", 32'(irq), 32'd1);
    rd_reg(3, d);
    if (n == 0) chk("R3 single conversion result", d, 32'(sum));
    else        chk("R4 averaged result", d, 32'(sum >> n));
    chk("R10 result upper bits zero", d & ~32'h3ff, 32'd0);
    chk("R5 irq cleared by result read", 32'(irq), 32'd0);
  endtask

  task automatic measure_clk(input int lo_exp, input int hi_exp);
    int runs_hi[$], runs_lo[$];
    int len = 0;
    bit prev = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i > 0 && adc_clk != prev) begin
        if (prev) runs_hi.push_back(len); else runs_lo.push_back(len);
        len = 1;
      end else len++;
      prev = adc_clk;
    end
    chk("R7 enough clock edges", 32'(runs_hi.size() >= 3), 32'd1);
    for (int k = 1; k < runs_lo.size(); k++) chk("R7 low phase length", 32'(runs_lo[k]), 32'(lo_exp));
    for (int k = 0; k < runs_hi.size(); k++) chk("R7 high phase length", 32'(runs_hi[k]), 32'(hi_exp));
  endtask

  initial begin
    logic [31:0] d;
    int q[$];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    chk("R1 irq low after reset", 32'(irq), 32'd0);
    chk("R1 adc_clk low after reset", 32'(adc_clk), 32'd0);
    for (int a = 0; a < 24; a++) begin
      rd_reg(a, d);
      chk("R1 register zero after reset", d, 32'd0);
    end

    // start strobe with the enable bit clear
    wr_reg(0, 32'h0000_0007);
    begin
      bit seen = 0;
      for (int i = 0; i < 6; i++) begin @(negedge clk); if (conv_start) seen = 1; end
      chk("R2 start without enable ignored", 32'(seen), 32'd0);
    end
    rd_reg(0, d);
    chk("R2 fields stored, start reads 0, not busy", d, 32'h0000_0006);

    // storage words
    wr_reg(2, 32'hffff_ffff);
    rd_reg(2, d);
    chk("R10 scan-rate width", d, 32'h0000_ffff);
    wr_reg(11, 32'hdead_beef);
    rd_reg(11, d);
    chk("R10 channel control word", d, 32'h0000_beef);
    rd_reg(12, d);
    chk("R10 neighbour channel control untouched", d, 32'd0);

    // converter clock
    wr_reg(1, 32'h23);
    wr_reg(0, 32'h10);
    measure_clk(3, 2);
    wr_reg(1, 32'h00);
    measure_clk(1, 1);
    wr_reg(1, 32'h14);
    measure_clk(4, 1);
    wr_reg(0, 32'h0);
    repeat (3) @(negedge clk);
    chk("R7 adc_clk low when disabled", 32'(adc_clk), 32'd0);

    q = {32'h2ab};
    run_seq(5, 0, 1, 0, 0, q);
    q = {1, 2, 3, 5};
    run_seq(2, 2, 0, 0, 0, q);
    q = {1023, 1023, 1023, 1023, 1023, 1023, 1023, 1023};
    run_seq(7, 3, 1, 1, 0, q);
    q = {100, 201};
    run_seq(0, 1, 0, 3, 0, q);
    q = {10, 20, 30, 41};
    run_seq(4, 2, 1, 2, 1, q);
    rd_reg(16 + 5, d);
    chk("R6 earlier channel data retained", d, 32'h2ab);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule